// File: doc/BRIEF.md
# PLL Power and CPU Clock Switch Sequencer

This block moves a processor clock between a fixed 26 MHz reference and a PLL output. A one-cycle request names an entry of a four-entry frequency table: index 0 is 26 MHz, and indices 1, 2 and 3 are 370, 540 and 720 MHz. For a PLL entry the block powers the PLL up in a fixed order. It then reprograms two clock-mux select fields and writes the PLL configuration word. For the reference entry it moves the muxes back to the reference in the opposite order and then powers the PLL down.

Every settle wait is counted on a free-running counter that advances on an external 13 MHz tick. The block uses 13 ticks per microsecond, and it computes elapsed time by modular subtraction, so a counter wrap does no harm.

The mux fields are changed through a small register-write port. The block issues a clear strobe, then an optional set strobe, then a one-hot update strobe. The clock state at power-on is unknown, so after reset the block forces the lowest entry and then the highest entry.

Top module: `pll_clk_sequencer`

## Requirements
- R1: Reset values are cg_sw=1, pll_pwr_on=0, pll_iso_en=1, pll_en=0, pll_cfg=0, bus_we=0, done=0 and busy=1. The block then runs a forced sequence to index 0 and after it a sequence to index 3, with busy high throughout. After both, cur_idx is 3.
- R2: Index 0 needs no PLL. Indices 1, 2 and 3 write pll_cfg with 0x831c7628, 0x8214c4ed and 0x821bb13c respectively, as the last action of the sequence.
- R3: Power-up order is: cg_sw goes low; then pll_pwr_on rises; then, at least 13 ticks later, pll_iso_en falls; then, at least 13 ticks later, pll_en rises.
- R4: Power-down order is: pll_en falls; then, at least 13 ticks later, pll_iso_en rises; then, at least 13 ticks later, pll_pwr_on falls. Power-down leaves cg_sw and pll_cfg unchanged.
- R5: A mux field write is a sequence of bus strobes on consecutive cycles. First comes a clear (bus_op=1, bus_data=0xF shifted to the field offset). Next comes a set (bus_op=2, bus_data=code shifted to the field offset), which is issued only when the code is nonzero. Last comes an update (bus_op=3, bus_data one-hot).
- R6: Mux A uses slot 22 at field offset 0, with update register 2 and bit 24; its PLL code is 8. Mux B uses slot 28 at field offset 16, with update register 3 and bit 18; its PLL code is 7. The reference code is 0 for both. bus_addr carries the slot for clear and set, and the update register index for update.
- R7: A move to a PLL entry runs power-up, then mux A, then mux B, then the configuration write. A move to index 0 runs mux B, then mux A, then power-down. Every PLL target runs the full up sequence, including a move from one PLL entry to another.
- R8: A request for the current index, or for an index of 4 or more, is ignored: no strobe, no output change, no done, and busy stays low.
- R9: A request made while busy is high is dropped and leaves no trace after the running sequence.
- R10: done pulses for exactly one cycle at the end of every sequence. In that same cycle cur_idx shows the new index, and busy is low unless the reset sequence continues.
- R11: Waits stay correct when the TIMER_W-bit tick counter wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse for each 13 MHz timer tick |
| req | input | 1 | Frequency change request strobe |
| req_idx | input | IDX_W | Requested table index |
| busy | output | 1 | A sequence is running; requests are dropped |
| done | output | 1 | One-cycle pulse when a sequence completes |
| cur_idx | output | IDX_W | Index currently in effect |
| cg_sw | output | 1 | Software clock-gate bit |
| pll_pwr_on | output | 1 | PLL power enable |
| pll_iso_en | output | 1 | PLL output isolation |
| pll_en | output | 1 | PLL enable |
| pll_cfg | output | 32 | PLL configuration word |
| bus_we | output | 1 | Mux register write strobe |
| bus_op | output | 2 | 1 clear, 2 set, 3 update |
| bus_addr | output | 5 | Mux slot, or update register index |
| bus_data | output | 32 | Write data |

## Verification
The bench targets four corner cases.

The first is the reference code of zero, which must drop the set strobe. A design that always writes would show an extra set strobe of value zero in the event stream.

The second is the order of the two muxes, which flips with direction. A design with a fixed order would show mux A first on the way down.

The third is the timer. The bench uses a 9-bit counter, so the 260-tick lock wait crosses a wrap often. A non-modular compare would end a wait early or hang.

The fourth is requests for the current index, for an index out of range, and made while busy. A design that leaks any of these would show an unexpected strobe or done pulse, or a wrong final index.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  localparam int unsigned ENTRIES      = 4;
  localparam int unsigned TICKS_PER_US = 13;
  localparam int unsigned US_SHORT     = 1;
  localparam int unsigned US_LOCK      = 20;

  localparam logic [1:0] OP_CLR = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_UPD = 2'd3;

  localparam logic [3:0] A_PLL    = 4'd8;
  localparam logic [3:0] B_PLL    = 4'd7;
  localparam logic [3:0] REF_CODE = 4'd0;

  typedef enum logic [3:0] {
    S_IDLE, S_UP_CG, S_UP_PWR, S_UP_ISO, S_UP_EN, S_WAIT,
    S_MUX_GO, S_MUX_WAIT, S_CFG, S_DN_EN, S_DN_ISO, S_DN_PWR, S_FIN
  } seq_state_t;

  // unit 0 = mux A, unit 1 = mux B
  function automatic logic [4:0] slot_of(input logic unit);
    return unit ? 5'd28 : 5'd22;
  endfunction

  function automatic int unsigned off_of(input logic unit);
    return unit ? 16 : 0;
  endfunction

  function automatic logic [4:0] ureg_of(input logic unit);
    return unit ? 5'd3 : 5'd2;
  endfunction

  function automatic int unsigned ubit_of(input logic unit);
    return unit ? 18 : 24;
  endfunction

  function automatic logic [31:0] pll_word(input logic [31:0] idx);
    case (idx)
      32'd1:   return 32'h831c7628;
      32'd2:   return 32'h8214c4ed;
      32'd3:   return 32'h821bb13c;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
  parameter int unsigned TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               arm,
  input  logic [TIMER_W-1:0] need,
  output logic               expired
);
  logic [TIMER_W-1:0] now_q, start_q, need_q, elapsed;
  logic               armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      now_q   <= '0;
      start_q <= '0;
      need_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (tick) now_q <= now_q + 1'b1;
      if (arm) begin
        start_q <= now_q + TIMER_W'(tick);
        need_q  <= need;
        armed_q <= 1'b1;
      end
    end
  end

  // modular difference: correct across counter wrap
  assign elapsed = now_q - start_q;
  assign expired = armed_q && (elapsed >= need_q);
endmodule

// File: rtl/clkseq_mux_writer.sv
module clkseq_mux_writer
  import clkseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        go,
  input  logic        unit,
  input  logic [3:0]  code,
  output logic        fin,
  output logic        bus_we,
  output logic [1:0]  bus_op,
  output logic [4:0]  bus_addr,
  output logic [31:0] bus_data
);
  typedef enum logic [1:0] {W_IDLE, W_CLR, W_SET, W_UPD} wph_t;
  wph_t       ph_q;
  logic       unit_q;
  logic [3:0] code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= W_IDLE;
      unit_q   <= 1'b0;
      code_q   <= '0;
      fin      <= 1'b0;
      bus_we   <= 1'b0;
      bus_op   <= '0;
      bus_addr <= '0;
      bus_data <= '0;
    end else begin
      fin <= 1'b0;
      case (ph_q)
        W_IDLE: begin
          bus_we <= 1'b0;
          if (go) begin
            unit_q   <= unit;
            code_q   <= code;
            bus_we   <= 1'b1;
            bus_op   <= OP_CLR;
            bus_addr <= slot_of(unit);
            bus_data <= 32'h0000_000F << off_of(unit);
            ph_q     <= W_CLR;
          end
        end
        W_CLR: begin
          if (code_q != 4'd0) begin
            bus_op   <= OP_SET;
            bus_addr <= slot_of(unit_q);
            bus_data <= 32'(code_q) << off_of(unit_q);
            ph_q     <= W_SET;
          end else begin
            bus_op   <= OP_UPD;
            bus_addr <= ureg_of(unit_q);
            bus_data <= 32'd1 << ubit_of(unit_q);
            ph_q     <= W_UPD;
          end
        end
        W_SET: begin
          bus_op   <= OP_UPD;
          bus_addr <= ureg_of(unit_q);
          bus_data <= 32'd1 << ubit_of(unit_q);
          ph_q     <= W_UPD;
        end
        default: begin
          bus_we   <= 1'b0;
          bus_op   <= '0;
          bus_addr <= '0;
          bus_data <= '0;
          fin      <= 1'b1;
          ph_q     <= W_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pll_clk_sequencer.sv
module pll_clk_sequencer
  import clkseq_pkg::*;
#(
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned TIMER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req,
  input  logic [IDX_W-1:0] req_idx,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] cur_idx,
  output logic             cg_sw,
  output logic             pll_pwr_on,
  output logic             pll_iso_en,
  output logic             pll_en,
  output logic [31:0]      pll_cfg,
  output logic             bus_we,
  output logic [1:0]       bus_op,
  output logic [4:0]       bus_addr,
  output logic [31:0]      bus_data
);
  localparam logic [IDX_W-1:0]   TOP_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [TIMER_W-1:0] T_SHORT = TIMER_W'(TICKS_PER_US * US_SHORT);
  localparam logic [TIMER_W-1:0] T_LOCK  = TIMER_W'(TICKS_PER_US * US_LOCK);

  seq_state_t       state_q, ret_q;
  logic [IDX_W-1:0] target_q, cur_q;
  logic             dir_up_q, step_q, boot_q;

  logic               arm, expired, go, unit, fin;
  logic [TIMER_W-1:0] need;
  logic [3:0]         code;
  logic               req_ok;

  always_comb begin
    arm  = 1'b0;
    need = '0;
    case (state_q)
      S_UP_PWR, S_UP_ISO, S_DN_EN, S_DN_ISO: begin arm = 1'b1; need = T_SHORT; end
      S_UP_EN:                               begin arm = 1'b1; need = T_LOCK;  end
      default: ;
    endcase
    go   = (state_q == S_MUX_GO);
    // up: A then B; down: B then A
    unit = dir_up_q ? step_q : ~step_q;
    code = dir_up_q ? (unit ? B_PLL : A_PLL) : REF_CODE;
  end

  assign req_ok = req && (32'(req_idx) < ENTRIES) && (req_idx != cur_q);

  clkseq_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .arm(arm), .need(need), .expired(expired)
  );

  clkseq_mux_writer u_mux (
    .clk(clk), .rst(rst), .go(go), .unit(unit), .code(code), .fin(fin),
    .bus_we(bus_we), .bus_op(bus_op), .bus_addr(bus_addr), .bus_data(bus_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_MUX_GO;   // forced move to the reference first
      ret_q      <= S_IDLE;
      target_q   <= '0;
      cur_q      <= TOP_IDX;
      dir_up_q   <= 1'b0;
      step_q     <= 1'b0;
      boot_q     <= 1'b1;
      done       <= 1'b0;
      cg_sw      <= 1'b1;
      pll_pwr_on <= 1'b0;
      pll_iso_en <= 1'b1;
      pll_en     <= 1'b0;
      pll_cfg    <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_ok) begin
            target_q <= req_idx;
            dir_up_q <= (req_idx != '0);
            step_q   <= 1'b0;
            state_q  <= (req_idx != '0) ? S_UP_CG : S_MUX_GO;
          end
        end
        S_UP_CG: begin
          cg_sw   <= 1'b0;
          state_q <= S_UP_PWR;
        end
        S_UP_PWR: begin
          pll_pwr_on <= 1'b1;
          ret_q      <= S_UP_ISO;
          state_q    <= S_WAIT;
        end
        S_UP_ISO: begin
          pll_iso_en <= 1'b0;
          ret_q      <= S_UP_EN;
          state_q    <= S_WAIT;
        end
        S_UP_EN: begin
          pll_en  <= 1'b1;
          ret_q   <= S_MUX_GO;
          state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (expired) state_q <= ret_q;
        end
        S_MUX_GO: state_q <= S_MUX_WAIT;
        S_MUX_WAIT: begin
          if (fin) begin
            if (!step_q) begin
              step_q  <= 1'b1;
              state_q <= S_MUX_GO;
            end else begin
              state_q <= dir_up_q ? S_CFG : S_DN_EN;
            end
          end
        end
        S_CFG: begin
          pll_cfg <= pll_word(32'(target_q));
          state_q <= S_FIN;
        end
        S_DN_EN: begin
          pll_en  <= 1'b0;
          ret_q   <= S_DN_ISO;
          state_q <= S_WAIT;
        end
        S_DN_ISO: begin
          pll_iso_en <= 1'b1;
          ret_q      <= S_DN_PWR;
          state_q    <= S_WAIT;
        end
        S_DN_PWR: begin
          pll_pwr_on <= 1'b0;
          state_q    <= S_FIN;
        end
        S_FIN: begin
          done  <= 1'b1;
          cur_q <= target_q;
          if (boot_q) begin
            boot_q   <= 1'b0;
            target_q <= TOP_IDX;
            dir_up_q <= 1'b1;
            step_q   <= 1'b0;
            state_q  <= S_UP_CG;
          end else begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state_q != S_IDLE);
  assign cur_idx = cur_q;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
  input logic        clk,
  input logic        rst,
  input logic        done,
  input logic        pll_pwr_on,
  input logic        pll_iso_en,
  input logic        pll_en,
  input logic        bus_we,
  input logic [1:0]  bus_op,
  input logic [31:0] bus_data
);
  // R3
  pll_en_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en) |-> (pll_pwr_on && !pll_iso_en));
  // R3
  iso_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_iso_en) |-> pll_pwr_on);
  // R4
  pwr_off_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_pwr_on) |-> (pll_iso_en && !pll_en));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  set_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_op == 2'd2) |-> (bus_data != 32'd0));
  // R5
  clr_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_op == 2'd1) |=> (bus_we && bus_op != 2'd1));
  // R6
  upd_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_op == 2'd3) |-> ($countones(bus_data) == 1));
endmodule

bind pll_clk_sequencer clkseq_chk u_chk (
  .clk(clk), .rst(rst), .done(done), .pll_pwr_on(pll_pwr_on),
  .pll_iso_en(pll_iso_en), .pll_en(pll_en), .bus_we(bus_we),
  .bus_op(bus_op), .bus_data(bus_data)
);

// File: tb/tb_pll_clk_sequencer.sv
`timescale 1ns/100ps
module tb_pll_clk_sequencer;
  localparam int IDX_W = 3;
  localparam int K_CLR = 1, K_SET = 2, K_UPD = 3, K_CG = 4, K_PWR = 5,
                 K_ISO = 6, K_EN = 7, K_CFG = 8, K_DONE = 9;

  logic clk = 0, rst = 1, tick = 0, req = 0;
  logic [IDX_W-1:0] req_idx = '0;
  logic busy, done, cg_sw, pll_pwr_on, pll_iso_en, pll_en, bus_we;
  logic [IDX_W-1:0] cur_idx;
  logic [31:0] pll_cfg, bus_data;
  logic [1:0] bus_op;
  logic [4:0] bus_addr;

  always #2.5 clk = ~clk;

  // R11: narrow 9-bit tick counter so the 260-tick lock wait crosses wraps
  pll_clk_sequencer #(.IDX_W(IDX_W), .TIMER_W(9)) dut (
    .clk(clk), .rst(rst), .tick(tick), .req(req), .req_idx(req_idx),
    .busy(busy), .done(done), .cur_idx(cur_idx), .cg_sw(cg_sw),
    .pll_pwr_on(pll_pwr_on), .pll_iso_en(pll_iso_en), .pll_en(pll_en),
    .pll_cfg(pll_cfg), .bus_we(bus_we), .bus_op(bus_op),
    .bus_addr(bus_addr), .bus_data(bus_data)
  );

  typedef struct { logic [40:0] ev; string tag; } exp_t;
  exp_t q[$];

  int checks = 0, errors = 0, cyc = 0, tick_cnt = 0, pend_need = 0;
  string pend_tag = "";
  bit mon_on = 0, finished = 0;
  logic p_cg = 1, p_pwr = 0, p_iso = 1, p_en = 0;
  logic [31:0] p_cfg = 0;
  // behavioural model of the control state
  logic m_cg = 1, m_pwr = 0, m_iso = 1, m_en = 0;
  logic [31:0] m_cfg = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [4:0] addr,
                      input logic [31:0] data, input string tag);
    exp_t e;
    e.ev = {4'(kind), addr, data};
    e.tag = tag;
    q.push_back(e);
  endtask

  // slot/offset/update constants per R6
  task automatic exp_mux(input bit is_b, input logic [3:0] code, input string first_tag);
    int off = is_b ? 16 : 0;
    logic [4:0] slot = is_b ? 5'd28 : 5'd22;
    push(K_CLR, slot, 32'hF << off, first_tag);
    if (code != 0) push(K_SET, slot, 32'(code) << off, "R5");
    push(K_UPD, is_b ? 5'd3 : 5'd2, 32'd1 << (is_b ? 18 : 24), "R6");
  endtask

  function automatic logic [31:0] word_of(input int idx);
    case (idx)
      1: return 32'h831c7628;
      2: return 32'h8214c4ed;
      3: return 32'h821bb13c;
      default: return 32'h0;
    endcase
  endfunction

  task automatic exp_seq(input int target, input bit boot);
    if (target != 0) begin
      if (m_cg)   push(K_CG, 0, 0, "R3");
      if (!m_pwr) push(K_PWR, 0, 1, "R3");
      if (m_iso)  push(K_ISO, 0, 0, "R3");
      if (!m_en)  push(K_EN, 0, 1, "R3");
      m_cg = 0; m_pwr = 1; m_iso = 0; m_en = 1;
      exp_mux(0, 4'd8, "R7");
      exp_mux(1, 4'd7, "R6");
      if (m_cfg != word_of(target)) push(K_CFG, 0, word_of(target), "R2");
      m_cfg = word_of(target);
    end else begin
      exp_mux(1, 4'd0, "R7");
      exp_mux(0, 4'd0, "R5");
      if (m_en)   push(K_EN, 0, 0, "R4");
      if (!m_iso) push(K_ISO, 0, 1, "R4");
      if (m_pwr)  push(K_PWR, 0, 0, "R4");
      m_en = 0; m_iso = 1; m_pwr = 0;
    end
    push(K_DONE, 0, 32'(target), boot ? "R1" : "R10");
  endtask

  task automatic see(input int kind, input logic [4:0] addr, input logic [31:0] data);
    logic [40:0] ev = {4'(kind), addr, data};
    if (pend_need > 0) begin
      chk(tick_cnt >= pend_need, pend_tag, "settle ticks", 64'(tick_cnt), 64'(pend_need));
      pend_need = 0;
    end
    if (q.size() == 0) begin
      chk(0, "R9", "unexpected event", 64'(ev), 64'(0));
    end else begin
      exp_t e = q.pop_front();
      chk(ev == e.ev, e.tag, "event", 64'(ev), 64'(e.ev));
    end
    if (kind == K_PWR && data[0])  begin pend_need = 13;  pend_tag = "R3";  end
    if (kind == K_ISO && !data[0]) begin pend_need = 13;  pend_tag = "R3";  end
    if (kind == K_EN && data[0])   begin pend_need = 260; pend_tag = "R11"; end
    if (kind == K_EN && !data[0])  begin pend_need = 13;  pend_tag = "R4";  end
    if (kind == K_ISO && data[0])  begin pend_need = 13;  pend_tag = "R4";  end
    tick_cnt = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor and tick source, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (bus_we) see(32'(bus_op), bus_addr, bus_data);
      if (cg_sw !== p_cg)       see(K_CG, 0, 32'(cg_sw));
      if (pll_pwr_on !== p_pwr) see(K_PWR, 0, 32'(pll_pwr_on));
      if (pll_iso_en !== p_iso) see(K_ISO, 0, 32'(pll_iso_en));
      if (pll_en !== p_en)      see(K_EN, 0, 32'(pll_en));
      if (pll_cfg !== p_cfg)    see(K_CFG, 0, pll_cfg);
      if (done)                 see(K_DONE, 0, 32'(cur_idx));
      p_cg = cg_sw; p_pwr = pll_pwr_on; p_iso = pll_iso_en;
      p_en = pll_en; p_cfg = pll_cfg;
    end
    if (cyc > 150000) begin
      chk(0, "R10", "watchdog expired", 64'(cyc), 64'(150000));
      finish_run();
    end
    tick = (cyc % 3 == 0);
    if (tick) tick_cnt++;
  end

  task automatic do_req(input int idx);
    @(negedge clk);
    req = 1; req_idx = IDX_W'(idx);
    @(negedge clk);
    req = 0;
  endtask

  task automatic wait_quiet();
    int n = 0;
    while ((q.size() != 0 || busy) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 20000, "R10", "sequence did not finish", 64'(q.size()), 64'(0));
  endtask

  task automatic ignored(input int idx, input int cur);
    do_req(idx);
    repeat (12) @(negedge clk);
    // R8: no busy, no index change; monitor flags any strobe or done
    chk(busy == 0, "R8", "busy after ignored request", 64'(busy), 64'(0));
    chk(cur_idx == IDX_W'(cur), "R8", "index after ignored request", 64'(cur_idx), 64'(cur));
  endtask

  task automatic run_to(input int target);
    exp_seq(target, 0);
    do_req(target);
    wait_quiet();
    chk(cur_idx == IDX_W'(target), "R10", "final index", 64'(cur_idx), 64'(target));
    chk(pll_cfg == m_cfg, "R2", "config word", 64'(pll_cfg), 64'(m_cfg));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(busy == 1, "R1", "busy in reset", 64'(busy), 64'(1));
    chk(cg_sw == 1 && pll_pwr_on == 0 && pll_iso_en == 1 && pll_en == 0, "R1",
        "power bits in reset", 64'({cg_sw, pll_pwr_on, pll_iso_en, pll_en}), 64'(4'b1010));
    chk(pll_cfg == 0 && bus_we == 0 && done == 0, "R1", "cfg/bus/done in reset",
        64'({pll_cfg, bus_we, done}), 64'(0));
    exp_seq(0, 1);
    exp_seq(3, 1);
    @(negedge clk);
    rst = 0; mon_on = 1;
    wait_quiet();
    chk(cur_idx == 3, "R1", "index after forced start", 64'(cur_idx), 64'(3));
    chk(pll_cfg == 32'h821bb13c, "R2", "cfg after forced start", 64'(pll_cfg), 64'h821bb13c);

    ignored(3, 3);
    ignored(5, 3);
    ignored(7, 3);

    // down to reference, with a stray request while busy (R9)
    exp_seq(0, 0);
    do_req(0);
    repeat (20) @(negedge clk);
    chk(busy == 1, "R9", "busy during sequence", 64'(busy), 64'(1));
    do_req(2);
    wait_quiet();
    chk(cur_idx == 0, "R9", "index after dropped request", 64'(cur_idx), 64'(0));
    chk(cg_sw == 0, "R4", "gate untouched by power-down", 64'(cg_sw), 64'(0));

    ignored(0, 0);
    run_to(1);
    run_to(2);   // R7: PLL to PLL still runs full sequence
    run_to(3);
    run_to(0);
    run_to(3);

    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R10", "leftover expected events", 64'(q.size()), 64'(0));
    finish_run();
  end
endmodule